// File: doc/BRIEF.md
# Dual-Group Phase-Adjustable Clock Divider

This block divides one fast oscillator clock into two output-group clocks, A and B. A toggle stage first halves the oscillator rate. The halved rate is the "input cycle" used throughout this brief, and one input cycle is two `clk_i` cycles. Each group then divides by a ratio picked from a fixed set of eleven values. Group B can be delayed against group A by a selectable number of phase steps. Each group can also be switched to pass an external reference clock through unchanged.

Configuration uses parallel inputs with a single write strobe and a 2-bit address:

| Address | Content |
|---|---|
| 0 | group A ratio code in data[3:0] |
| 1 | group B ratio code in data[3:0] |
| 2 | phase index in data[6:0] |
| 3 | bypass bits: data[0] for group A, data[1] for group B |

A ratio or bypass write stops both dividers for one cycle, then restarts them together. A phase write made while the dividers run is held back until the next rising edge of group A.

Top module: `phdiv_top`

## Requirements
- R1: Ratio codes 0 to 10 select the divide ratios 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 and 80, in that order. A non-bypassed group output has a period of ratio input cycles, which is 2×ratio `clk_i` cycles.
- R2: While running, `div2_o` toggles on every `clk_i` edge. The group counters advance once per input cycle.
- R3: The two groups take their ratios independently. Group A's period follows its own code whatever group B's code is.
- R4: For ratios of 2 and above, a group output is high for ceil(ratio/2) input cycles of each period. With ratio 1 the output follows `div2_o`, high for one `clk_i` cycle out of two.
- R5: After a restart, the first rising edge of B comes d input cycles after the first rising edge of A, where d = index × step. The step is 5 input cycles when B's ratio is a multiple of 5, and 1 input cycle otherwise. The number of valid indices is ratio/5 in the first case and ratio in the second.
- R6: A phase index at or above the number of valid positions for B's ratio behaves as the last valid position. While that holds, `phase_clamp_o` reads 1; otherwise it reads 0.
- R7: A ratio write with a code of 11 to 15 is ignored. The stored ratio stays as it was and the dividers keep running.
- R8: After a ratio write with a legal code, or after any bypass write, both non-bypassed outputs are low for the next `clk_i` cycle. Group A's first rising edge then comes on the following edge.
- R9: A phase write made while running is applied at the next rising edge of A. B's next rising edge follows d input cycles after that edge.
- R10: A bypassed group output equals `ref_i`.
- R11: During reset both group outputs and `div2_o` are low. Reset selects ratio 1 for both groups, phase index 0 and no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock feeding the divide-by-two stage |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock routed to a bypassed group |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address (0 ratio A, 1 ratio B, 2 phase, 3 bypass) |
| cfg_data_i | input | 7 | Configuration write data |
| div2_o | output | 1 | Divide-by-two stage output |
| grp_a_o | output | 1 | Group A clock |
| grp_b_o | output | 1 | Group B clock |
| phase_clamp_o | output | 1 | Phase index exceeds the valid positions for B's ratio |

## Verification
The ratio set and the phase-step rule are fixed, so the bench builds the block as it stands and sweeps all eleven ratio codes for group B. For each one it tries every phase index up to one past the last valid position. Group A's code is rotated through the sweep, so mixed-ratio pairs, odd duty cycles, the ratio-1 pass-through and the clamp boundary all come up. Further directed runs cover an illegal ratio code, a phase update while running, bypass and the reset state.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

    localparam int SEL_W       = 4;
    localparam int NUM_SEL     = 11;
    localparam int CNT_W       = 7;
    localparam int PH_W        = 7;
    localparam int CFG_DW      = 7;
    localparam int COARSE_STEP = 5;
    localparam int NUM_GRP     = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ADDR_RATIO_A = 2'd0,
        ADDR_RATIO_B = 2'd1,
        ADDR_PHASE   = 2'd2,
        ADDR_BYPASS  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             bypass;
    } grp_cfg_t;

    function automatic cnt_t ratio_of(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd0:    return cnt_t'(1);
            4'd1:    return cnt_t'(2);
            4'd2:    return cnt_t'(4);
            4'd3:    return cnt_t'(5);
            4'd4:    return cnt_t'(8);
            4'd5:    return cnt_t'(10);
            4'd6:    return cnt_t'(16);
            4'd7:    return cnt_t'(20);
            4'd8:    return cnt_t'(32);
            4'd9:    return cnt_t'(40);
            4'd10:   return cnt_t'(80);
            default: return cnt_t'(1);
        endcase
    endfunction

    function automatic logic is_coarse(input cnt_t r);
        return (int'(r) % COARSE_STEP) == 0;
    endfunction

    function automatic cnt_t num_pos(input cnt_t r);
        return is_coarse(r) ? cnt_t'(int'(r) / COARSE_STEP) : r;
    endfunction

    function automatic cnt_t step_of(input cnt_t r);
        return is_coarse(r) ? cnt_t'(COARSE_STEP) : cnt_t'(1);
    endfunction

    function automatic cnt_t high_len(input cnt_t r);
        return cnt_t'((int'(r) + 1) / 2);
    endfunction

endpackage

// File: rtl/phdiv_group.sv
module phdiv_group
    import phdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic pre_i,
    input  logic load_i,
    input  cnt_t start_i,
    input  cnt_t ratio_i,
    output logic wrap_o,
    output logic lvl_o
);

    cnt_t cnt_q;
    cnt_t hi_len;

    assign hi_len = high_len(ratio_i);
    assign wrap_o = tick_i && (cnt_q == ratio_i - 1'b1);
    assign lvl_o  = (ratio_i == cnt_t'(1)) ? pre_i : (cnt_q < hi_len);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= start_i;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/phdiv_top.sv
module phdiv_top
    import phdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_data_i,
    output logic              div2_o,
    output logic              grp_a_o,
    output logic              grp_b_o,
    output logic              phase_clamp_o
);

    localparam int LEAD   = 0;
    localparam int FOLLOW = 1;

    grp_cfg_t          cfg_a_q, cfg_b_q;
    logic [PH_W-1:0]   phase_q;
    logic              pend_q, run_q, pre_q;
    logic [NUM_GRP-1:0] armed_q;

    cfg_addr_e         addr_w;
    logic              sel_ok, restart_req, phase_wr, tick, apply;
    cnt_t              npos_b, step_b, eff_idx, delay_b;
    cnt_t              ratio_v [NUM_GRP];
    cnt_t              start_v [NUM_GRP];
    logic [NUM_GRP-1:0] arm_init_v, wrap_v, lvl_v, load_v, byp_v, out_v;

    assign addr_w      = cfg_addr_e'(cfg_addr_i);
    assign sel_ok      = cfg_data_i[SEL_W-1:0] < SEL_W'(NUM_SEL);
    assign phase_wr    = cfg_we_i && (addr_w == ADDR_PHASE);
    assign restart_req = cfg_we_i &&
                         (((addr_w == ADDR_RATIO_A || addr_w == ADDR_RATIO_B) && sel_ok) ||
                          (addr_w == ADDR_BYPASS));
    assign tick        = run_q && !pre_q;
    assign apply       = pend_q && wrap_v[LEAD];

    // configuration, predivider and run control
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_a_q <= '0;
            cfg_b_q <= '0;
            phase_q <= '0;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            pre_q   <= 1'b0;
        end else begin
            run_q <= !restart_req;
            pre_q <= restart_req ? 1'b0 : !pre_q;
            if (restart_req)   pend_q <= 1'b0;
            else if (phase_wr) pend_q <= 1'b1;
            else if (apply)    pend_q <= 1'b0;
            if (cfg_we_i) begin
                case (addr_w)
                    ADDR_RATIO_A: if (sel_ok) cfg_a_q.sel <= cfg_data_i[SEL_W-1:0];
                    ADDR_RATIO_B: if (sel_ok) cfg_b_q.sel <= cfg_data_i[SEL_W-1:0];
                    ADDR_PHASE:   phase_q <= cfg_data_i[PH_W-1:0];
                    ADDR_BYPASS: begin
                        cfg_a_q.bypass <= cfg_data_i[0];
                        cfg_b_q.bypass <= cfg_data_i[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // phase position of the follower group
    assign ratio_v[LEAD]   = ratio_of(cfg_a_q.sel);
    assign ratio_v[FOLLOW] = ratio_of(cfg_b_q.sel);
    assign npos_b          = num_pos(ratio_v[FOLLOW]);
    assign step_b          = step_of(ratio_v[FOLLOW]);
    assign phase_clamp_o   = cnt_t'(phase_q) >= npos_b;
    assign eff_idx         = phase_clamp_o ? npos_b - 1'b1 : cnt_t'(phase_q);
    assign delay_b         = eff_idx * step_b;

    assign start_v[LEAD]      = '0;
    assign arm_init_v[LEAD]   = 1'b1;
    assign start_v[FOLLOW]    = (delay_b == '0) ? '0 : ratio_v[FOLLOW] - delay_b;
    assign arm_init_v[FOLLOW] = (delay_b == '0);

    assign load_v[LEAD]   = !run_q;
    assign load_v[FOLLOW] = !run_q || apply;
    assign byp_v[LEAD]    = cfg_a_q.bypass;
    assign byp_v[FOLLOW]  = cfg_b_q.bypass;

    for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
        phdiv_group u_grp (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .tick_i  (tick),
            .pre_i   (pre_q),
            .load_i  (load_v[g]),
            .start_i (start_v[g]),
            .ratio_i (ratio_v[g]),
            .wrap_o  (wrap_v[g]),
            .lvl_o   (lvl_v[g])
        );
        assign out_v[g] = byp_v[g] ? ref_i : (run_q && armed_q[g] && lvl_v[g]);
    end

    // a group stays silent until its counter first passes zero
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= '0;
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (load_v[g])      armed_q[g] <= arm_init_v[g];
                else if (wrap_v[g]) armed_q[g] <= 1'b1;
            end
        end
    end

    assign div2_o  = pre_q;
    assign grp_a_o = out_v[LEAD];
    assign grp_b_o = out_v[FOLLOW];

endmodule

// File: rtl/phdiv_chk.sv
module phdiv_chk
    import phdiv_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              cfg_we_i,
    input logic [1:0]        cfg_addr_i,
    input logic [CFG_DW-1:0] cfg_data_i,
    input logic              div2_o,
    input logic              grp_a_o,
    input logic              grp_b_o,
    input logic              run_q,
    input logic              tick,
    input logic              pend_q,
    input logic              wrap_a,
    input logic              byp_a,
    input logic              byp_b,
    input cnt_t              ratio_a
);

    // R8
    restart_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_we_i && cfg_addr_i == 2'd1 && cfg_data_i[SEL_W-1:0] < SEL_W'(NUM_SEL) && !byp_b)
        |=> !grp_b_o);

    // R2
    div2_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && $past(run_q)) |-> (div2_o != $past(div2_o)));

    // R4
    a_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && !tick && !cfg_we_i && !byp_a && ratio_a != cnt_t'(1)) |=> $stable(grp_a_o));

    // R9
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_q && wrap_a && !cfg_we_i) |=> !pend_q);

    // R9
    apply_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_q && wrap_a && !cfg_we_i && !byp_a) |=> grp_a_o);

endmodule

bind phdiv_top phdiv_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_data_i (cfg_data_i),
    .div2_o     (div2_o),
    .grp_a_o    (grp_a_o),
    .grp_b_o    (grp_b_o),
    .run_q      (run_q),
    .tick       (tick),
    .pend_q     (pend_q),
    .wrap_a     (wrap_v[0]),
    .byp_a      (cfg_a_q.bypass),
    .byp_b      (cfg_b_q.bypass),
    .ratio_a    (ratio_v[0])
);

// File: tb/phdiv_top_tb_top.sv
module phdiv_top_tb_top;
    import phdiv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 340;
    localparam int WDOG       = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_s = 1'b0;
    logic              we = 1'b0;
    logic [1:0]        addr = '0;
    logic [CFG_DW-1:0] data = '0;
    logic              div2, ga, gb, clampw;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    int  rat [NUM_SEL] = '{1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80};

    always #(CLK_PERIOD/2) clk = ~clk;

    phdiv_top dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .ref_i         (ref_s),
        .cfg_we_i      (we),
        .cfg_addr_i    (addr),
        .cfg_data_i    (data),
        .div2_o        (div2),
        .grp_a_o       (ga),
        .grp_b_o       (gb),
        .phase_clamp_o (clampw)
    );

    function automatic int npos_tb(int r);
        return (r % 5 == 0) ? r / 5 : r;
    endfunction

    function automatic int step_tb(int r);
        return (r % 5 == 0) ? 5 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we   = 1'b1;
        addr = 2'(a);
        data = CFG_DW'(d);
        @(negedge clk);
        we   = 1'b0;
    endtask

    // called at the negedge right after a restart edge
    task automatic measure(input int ra, input int rb, input int d);
        int  ta1 = -1, ta2 = -1, tb1 = -1, tbf = -1;
        bit  pa, pb;
        int  wexp;
        check(ga == 1'b0 && gb == 1'b0, "R8 outputs low in hold cycle", int'(ga) + int'(gb), 0);
        pa = ga;
        pb = gb;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (ga && !pa) begin
                if (ta1 < 0) ta1 = k;
                else if (ta2 < 0) ta2 = k;
            end
            if (gb && !pb && ta1 >= 0 && tb1 < 0) tb1 = k;
            if (!gb && pb && tb1 >= 0 && tbf < 0) tbf = k;
            pa = ga;
            pb = gb;
        end
        check(ta1 == 1, "R8 first A rise one cycle after hold", ta1, 1);
        check(ta1 >= 0 && tb1 >= 0 && tb1 - ta1 == 2 * d, "R5 B offset", tb1 - ta1, 2 * d);
        check(ta2 >= 0 && ta2 - ta1 == 2 * ra, "R1 R3 A period", ta2 - ta1, 2 * ra);
        wexp = (rb == 1) ? 1 : 2 * ((rb + 1) / 2);
        check(tbf >= 0 && tbf - tb1 == wexp, "R4 B high time", tbf - tb1, wexp);
    endtask

    task automatic a_period(output int p);
        int t1 = -1;
        int t2 = -1;
        bit pa;
        pa = ga;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (ga && !pa) begin
                if (t1 < 0) t1 = k;
                else if (t2 < 0) t2 = k;
            end
            pa = ga;
        end
        p = (t1 >= 0 && t2 >= 0) ? t2 - t1 : -1;
    endtask

    initial begin
        #(CLK_PERIOD * WDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int  p;
        bit  pd;
        int  ta, tb;
        bit  pa, pb;

        // R11 reset state
        repeat (4) begin
            @(negedge clk);
            check(ga == 1'b0 && gb == 1'b0 && div2 == 1'b0, "R11 low in reset",
                  int'(ga) + int'(gb) + int'(div2), 0);
        end
        rst = 1'b0;
        check(clampw == 1'b0, "R11 reset phase index 0", int'(clampw), 0);
        measure(1, 1, 0);   // R11 defaults: ratio 1 both, phase 0

        // R2 predivider toggles every clk edge
        pd = div2;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(div2 != pd, "R2 div2 toggle", int'(div2), int'(!pd));
            pd = div2;
        end

        // R1 R3 R4 R5 R6 sweep over all B ratios and phase indices
        for (int sb = 0; sb < NUM_SEL; sb++) begin
            for (int idx = 0; idx <= npos_tb(rat[sb]); idx++) begin
                int sa, np, eff;
                sa  = (sb * 3 + idx) % NUM_SEL;
                np  = npos_tb(rat[sb]);
                eff = (idx >= np) ? np - 1 : idx;
                wr(2, idx);
                wr(0, sa);
                wr(1, sb);
                check(clampw == (idx >= np), "R6 clamp flag", int'(clampw), int'(idx >= np));
                measure(rat[sa], rat[sb], eff * step_tb(rat[sb]));
            end
        end

        // R7 illegal ratio code ignored
        wr(0, 3);
        wr(1, 0);
        wr(0, 12);
        a_period(p);
        check(p == 10, "R7 ratio code 12 ignored", p, 10);
        wr(0, 15);
        a_period(p);
        check(p == 10, "R7 ratio code 15 ignored", p, 10);

        // R9 phase update while running
        wr(2, 0);
        wr(0, 2);
        wr(1, 4);
        repeat (37) @(negedge clk);
        wr(2, 3);
        ta = -1;
        tb = -1;
        pa = ga;
        pb = gb;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (ga && !pa && ta < 0) ta = k;
            if (gb && !pb && ta >= 0 && tb < 0) tb = k;
            pa = ga;
            pb = gb;
        end
        check(ta >= 0 && tb >= 0 && tb - ta == 6, "R9 running phase update", tb - ta, 6);

        // R10 bypass
        wr(3, 3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ref_s = 1'(i % 2);
            #1;
            check(ga == ref_s && gb == ref_s, "R10 bypass follows ref",
                  int'(ga) * 2 + int'(gb), int'(ref_s) * 3);
        end
        wr(3, 0);
        measure(4, 8, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule